// File: doc/BRIEF.md
# Segment Descriptor Cache

This block keeps recently used segment descriptors close to the address translation unit of a segmented virtual memory system. It holds 32 direct-mapped entries, split into four sections of eight. The top two bits of a virtual address choose the section, and three middle bits choose the entry inside that section. Each entry keeps a compressed form of the two-word descriptor: a low word made of the access and length fields plus an address tag, and a high word made of the segment base, four flag bits and a good bit. On a hit the cache rebuilds both descriptor words. The valid and present bits are always set in the rebuilt form, because only descriptors that have both bits set are ever stored.

The translation unit uses the block as follows. It posts a lookup and receives a registered result one cycle later. After a table walk it offers the fetched descriptor for fill. The operating-system side can invalidate one entry, one section or the whole cache, and can mark an entry's segment as modified. A lookup that arrives in the same cycle as a maintenance operation is dropped, and the translation unit reposts it.

Top module: `seg_desc_cache`

## Requirements
- R1: After reset every entry has its good bit cleared, so every lookup returns a miss.
- R2: Entry number = va[31:30]*8 + va[19:17], and tag = va[29:20]. A lookup hits only when the addressed entry's good bit is set and its stored tag equals the lookup tag.
- R3: A fill stores the descriptor and sets the good bit only when the record-enable input is high and descriptor word 0 has both bit 6 (valid) and bit 0 (present) set. In every other case the cache is left unchanged.
- R4: On a hit, word 0 reads back as {stored w0[31:10], 3'b000, 1, 0, flags[3:0], 1}. The flags are w0[4:1] as they were filled, with bit 1 raised by any later modified update.
- R5: On a hit, word 1 reads back as the filled w1 with bits [4:0] cleared. On a miss both output words are zero.
- R6: An entry flush clears the good bit of the entry addressed by its virtual address, whatever tag that entry holds.
- R7: A section flush clears the good bits of all eight entries of the named section and leaves the other sections untouched.
- R8: A full flush clears every good bit.
- R9: A modified update sets flag bit 1 (read back as w0 bit 1) of the addressed entry. The good bit and tag of that entry are not changed.
- R10: A lookup requested in cycle t is answered in cycle t+1 with result-valid high. When no lookup was requested, result-valid is low and hit is low.
- R11: At most one maintenance operation takes effect per cycle, in the priority order: full flush, section flush, entry flush, fill, modified update. Any active maintenance request drops a lookup posted in the same cycle, and result-valid stays low for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_valid | output | 1 | Registered: a lookup result is presented |
| lk_hit | output | 1 | Registered: lookup hit |
| lk_word0 | output | 32 | Rebuilt descriptor word 0 |
| lk_word1 | output | 32 | Rebuilt descriptor word 1 |
| fill_en | input | 1 | Fill request |
| fill_rec | input | 1 | Fault recording enabled for the access offering the fill |
| fill_va | input | 32 | Virtual address of the fill |
| fill_w0 | input | 32 | Descriptor word 0 |
| fill_w1 | input | 32 | Descriptor word 1 |
| inv_ent_en | input | 1 | Single-entry flush |
| inv_ent_va | input | 32 | Address selecting the entry to flush |
| inv_sect_en | input | 1 | Section flush |
| inv_sect_id | input | 2 | Section to flush |
| inv_all_en | input | 1 | Whole-cache flush |
| mod_en | input | 1 | Modified-bit update |
| mod_va | input | 32 | Address selecting the entry to mark |

## Verification
The hardest cases to reach are two tags that share one index and replace each other in turn, and maintenance requests of several kinds arriving together. A random stimulus stream with few distinct addresses makes both common. It draws addresses from a small pool of sections, indices and tags, so index collisions, stale-tag misses and flushes of live entries happen often. Each maintenance input is raised on its own probability, so the priority between operations and the dropping of lookups are exercised in many combinations. A reference model in the bench follows the cache cycle by cycle.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    localparam int VA_W      = 32;
    localparam int SECT_W    = 2;
    localparam int IDX_W     = 3;
    localparam int TAG_W     = 10;
    localparam int IDX_LSB   = 17;
    localparam int TAG_LSB   = IDX_LSB + IDX_W;
    localparam int NUM_SECT  = 1 << SECT_W;
    localparam int SECT_ENT  = 1 << IDX_W;
    localparam int NUM_ENT   = NUM_SECT * SECT_ENT;
    localparam int ENT_W     = SECT_W + IDX_W;
    localparam int LOW_HI_W  = VA_W - TAG_W;
    localparam int BASE_LSB  = 5;

    typedef logic [ENT_W-1:0] ent_idx_t;

    typedef struct packed {
        logic [LOW_HI_W-1:0] acc_len;
        logic [TAG_W-1:0]    tag;
    } low_word_t;

    typedef struct packed {
        logic [VA_W-BASE_LSB-1:0] base;
        logic [3:0]               flags;
        logic                     good;
    } high_word_t;

    typedef enum logic [2:0] {
        OP_NONE, OP_ALL, OP_SECT, OP_ENT, OP_FILL, OP_MOD
    } maint_op_e;

    function automatic ent_idx_t va_entry(input logic [VA_W-1:0] va);
        return {va[VA_W-1 -: SECT_W], va[IDX_LSB +: IDX_W]};
    endfunction

    function automatic logic [TAG_W-1:0] va_tag(input logic [VA_W-1:0] va);
        return va[TAG_LSB +: TAG_W];
    endfunction

    function automatic logic desc_cacheable(input logic [VA_W-1:0] w0);
        return w0[6] & w0[0];
    endfunction

    function automatic logic [VA_W-1:0] rebuild_w0(input low_word_t lo,
                                                   input high_word_t hi);
        return {lo.acc_len, 3'b000, 1'b1, 1'b0, hi.flags, 1'b1};
    endfunction

    function automatic logic [VA_W-1:0] rebuild_w1(input high_word_t hi);
        return {hi.base, {BASE_LSB{1'b0}}};
    endfunction
endpackage

// File: rtl/sdc_maint_ctrl.sv
module sdc_maint_ctrl
    import sdc_pkg::*;
(
    input  logic                 fill_en,
    input  logic                 fill_rec,
    input  logic [VA_W-1:0]      fill_va,
    input  logic [VA_W-1:0]      fill_w0,
    input  logic [VA_W-1:0]      fill_w1,
    input  logic                 inv_ent_en,
    input  logic [VA_W-1:0]      inv_ent_va,
    input  logic                 inv_sect_en,
    input  logic [SECT_W-1:0]    inv_sect_id,
    input  logic                 inv_all_en,
    input  logic                 mod_en,
    input  logic [VA_W-1:0]      mod_va,
    output logic [NUM_ENT-1:0]   clr_good,
    output logic                 wr_en,
    output ent_idx_t             wr_idx,
    output low_word_t            wr_low,
    output high_word_t           wr_high,
    output logic                 set_mod,
    output ent_idx_t             mod_idx,
    output logic                 busy
);
    maint_op_e op;

    always_comb begin
        if (inv_all_en)       op = OP_ALL;
        else if (inv_sect_en) op = OP_SECT;
        else if (inv_ent_en)  op = OP_ENT;
        else if (fill_en)     op = OP_FILL;
        else if (mod_en)      op = OP_MOD;
        else                  op = OP_NONE;
    end

    assign busy = (op != OP_NONE);

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_clr
        localparam int SECT_OF = e / SECT_ENT;
        always_comb begin
            unique case (op)
                OP_ALL:  clr_good[e] = 1'b1;
                OP_SECT: clr_good[e] = (inv_sect_id == SECT_W'(SECT_OF));
                OP_ENT:  clr_good[e] = (va_entry(inv_ent_va) == ENT_W'(e));
                default: clr_good[e] = 1'b0;
            endcase
        end
    end

    always_comb begin
        wr_en           = (op == OP_FILL) && fill_rec && desc_cacheable(fill_w0);
        wr_idx          = va_entry(fill_va);
        wr_low.acc_len  = fill_w0[VA_W-1:TAG_W];
        wr_low.tag      = va_tag(fill_va);
        wr_high.base    = fill_w1[VA_W-1:BASE_LSB];
        wr_high.flags   = fill_w0[4:1];
        wr_high.good    = 1'b1;
        set_mod         = (op == OP_MOD);
        mod_idx         = va_entry(mod_va);
    end
endmodule

// File: rtl/sdc_store.sv
module sdc_store
    import sdc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_ENT-1:0]   clr_good,
    input  logic                 wr_en,
    input  ent_idx_t             wr_idx,
    input  low_word_t            wr_low,
    input  high_word_t           wr_high,
    input  logic                 set_mod,
    input  ent_idx_t             mod_idx,
    output low_word_t            low_q  [NUM_ENT],
    output high_word_t           high_q [NUM_ENT]
);
    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                low_q[e]  <= '0;
                high_q[e] <= '0;
            end else if (clr_good[e]) begin
                high_q[e].good <= 1'b0;
            end else if (wr_en && wr_idx == ENT_W'(e)) begin
                low_q[e]  <= wr_low;
                high_q[e] <= wr_high;
            end else if (set_mod && mod_idx == ENT_W'(e)) begin
                high_q[e].flags[0] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdc_probe.sv
module sdc_probe
    import sdc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic                 drop,
    input  logic [VA_W-1:0]      va,
    input  low_word_t            low_q  [NUM_ENT],
    input  high_word_t           high_q [NUM_ENT],
    output logic                 res_valid,
    output logic                 res_hit,
    output logic [VA_W-1:0]      res_w0,
    output logic [VA_W-1:0]      res_w1
);
    ent_idx_t   sel;
    low_word_t  lo;
    high_word_t hi;
    logic       hit_c;

    always_comb begin
        sel   = va_entry(va);
        lo    = low_q[sel];
        hi    = high_q[sel];
        hit_c = hi.good && (lo.tag == va_tag(va));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_w0    <= '0;
            res_w1    <= '0;
        end else begin
            res_valid <= req && !drop;
            res_hit   <= req && !drop && hit_c;
            if (req && !drop && hit_c) begin
                res_w0 <= rebuild_w0(lo, hi);
                res_w1 <= rebuild_w1(hi);
            end else begin
                res_w0 <= '0;
                res_w1 <= '0;
            end
        end
    end
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
    import sdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [31:0]       lk_va,
    output logic              lk_valid,
    output logic              lk_hit,
    output logic [31:0]       lk_word0,
    output logic [31:0]       lk_word1,
    input  logic              fill_en,
    input  logic              fill_rec,
    input  logic [31:0]       fill_va,
    input  logic [31:0]       fill_w0,
    input  logic [31:0]       fill_w1,
    input  logic              inv_ent_en,
    input  logic [31:0]       inv_ent_va,
    input  logic              inv_sect_en,
    input  logic [1:0]        inv_sect_id,
    input  logic              inv_all_en,
    input  logic              mod_en,
    input  logic [31:0]       mod_va
);
    logic [NUM_ENT-1:0] clr_good;
    logic               wr_en;
    ent_idx_t           wr_idx;
    low_word_t          wr_low;
    high_word_t         wr_high;
    logic               set_mod;
    ent_idx_t           mod_idx;
    logic               busy;
    low_word_t          low_q  [NUM_ENT];
    high_word_t         high_q [NUM_ENT];

    sdc_maint_ctrl u_ctrl (
        .fill_en     (fill_en),
        .fill_rec    (fill_rec),
        .fill_va     (fill_va),
        .fill_w0     (fill_w0),
        .fill_w1     (fill_w1),
        .inv_ent_en  (inv_ent_en),
        .inv_ent_va  (inv_ent_va),
        .inv_sect_en (inv_sect_en),
        .inv_sect_id (inv_sect_id),
        .inv_all_en  (inv_all_en),
        .mod_en      (mod_en),
        .mod_va      (mod_va),
        .clr_good    (clr_good),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_low      (wr_low),
        .wr_high     (wr_high),
        .set_mod     (set_mod),
        .mod_idx     (mod_idx),
        .busy        (busy)
    );

    sdc_store u_store (
        .clk      (clk),
        .rst      (rst),
        .clr_good (clr_good),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_low   (wr_low),
        .wr_high  (wr_high),
        .set_mod  (set_mod),
        .mod_idx  (mod_idx),
        .low_q    (low_q),
        .high_q   (high_q)
    );

    sdc_probe u_probe (
        .clk       (clk),
        .rst       (rst),
        .req       (lk_req),
        .drop      (busy),
        .va        (lk_va),
        .low_q     (low_q),
        .high_q    (high_q),
        .res_valid (lk_valid),
        .res_hit   (lk_hit),
        .res_w0    (lk_word0),
        .res_w1    (lk_word1)
    );
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker (
    input logic        clk,
    input logic        rst,
    input logic        lk_req,
    input logic        lk_valid,
    input logic        lk_hit,
    input logic [31:0] lk_word0,
    input logic [31:0] lk_word1,
    input logic        fill_en,
    input logic        inv_ent_en,
    input logic        inv_sect_en,
    input logic        inv_all_en,
    input logic        mod_en
);
    logic maint;
    assign maint = fill_en | inv_ent_en | inv_sect_en | inv_all_en | mod_en;

    // R10: a result appears only for a lookup posted the cycle before
    a_r10_result_follows_req: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> $past(lk_req));

    // R10: no hit without a result
    a_r10_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_valid);

    // R11: a lookup that meets maintenance is dropped
    a_r11_drop_on_maint: assert property (@(posedge clk) disable iff (rst)
        (lk_req && maint) |=> !lk_valid);

    // R4: rebuilt word 0 carries valid and present
    a_r4_vp_set: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_word0[6] && lk_word0[0] && lk_word0[9:7] == 3'b000 && !lk_word0[5]));

    // R5: rebuilt word 1 has its low bits clear; miss gives zero words
    a_r5_w1_low_clear: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_word1[4:0] == 5'd0));
    a_r5_miss_zero: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_word0 == 32'd0 && lk_word1 == 32'd0));

    // R8: a lookup right after a full flush misses
    a_r8_all_flush_miss: assert property (@(posedge clk) disable iff (rst)
        (inv_all_en && !lk_req) |=> (lk_req |=> !lk_hit));
endmodule

bind seg_desc_cache sdc_checker u_sdc_checker (
    .clk         (clk),
    .rst         (rst),
    .lk_req      (lk_req),
    .lk_valid    (lk_valid),
    .lk_hit      (lk_hit),
    .lk_word0    (lk_word0),
    .lk_word1    (lk_word1),
    .fill_en     (fill_en),
    .inv_ent_en  (inv_ent_en),
    .inv_sect_en (inv_sect_en),
    .inv_all_en  (inv_all_en),
    .mod_en      (mod_en)
);

// File: tb/tb_seg_desc_cache.sv
module tb_seg_desc_cache;
    logic        clk = 1'b0;
    logic        rst;
    logic        lk_req;
    logic [31:0] lk_va;
    logic        lk_valid, lk_hit;
    logic [31:0] lk_word0, lk_word1;
    logic        fill_en, fill_rec;
    logic [31:0] fill_va, fill_w0, fill_w1;
    logic        inv_ent_en;
    logic [31:0] inv_ent_va;
    logic        inv_sect_en;
    logic [1:0]  inv_sect_id;
    logic        inv_all_en, mod_en;
    logic [31:0] mod_va;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model: tag, data words, good flag, flags per entry
    logic [9:0]  m_tag  [32];
    logic [21:0] m_acc  [32];
    logic [26:0] m_base [32];
    logic [3:0]  m_flg  [32];
    logic        m_good [32];

    always #2 clk = ~clk;

    seg_desc_cache dut (.*);

    function automatic int ent_of(input logic [31:0] va);
        return {va[31:30], va[19:17]};
    endfunction

    function automatic logic [31:0] mk_va(input int sect, input int idx, input int tag);
        logic [31:0] v;
        v = $urandom;
        v[31:30] = sect[1:0];
        v[29:20] = tag[9:0];
        v[19:17] = idx[2:0];
        return v;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        lk_req = 0; lk_va = 0; fill_en = 0; fill_rec = 0; fill_va = 0;
        fill_w0 = 0; fill_w1 = 0; inv_ent_en = 0; inv_ent_va = 0;
        inv_sect_en = 0; inv_sect_id = 0; inv_all_en = 0; mod_en = 0; mod_va = 0;
    endtask

    // one cycle: inputs already driven; compute expectation, clock, check, update model
    task automatic cycle(input string req);
        logic        e_valid, e_hit;
        logic [31:0] e_w0, e_w1;
        int          e;
        bit          maint;
        maint   = inv_all_en | inv_sect_en | inv_ent_en | fill_en | mod_en;
        e_valid = lk_req && !maint;
        e       = ent_of(lk_va);
        e_hit   = e_valid && m_good[e] && m_tag[e] == lk_va[29:20];
        e_w0    = e_hit ? {m_acc[e], 3'b000, 1'b1, 1'b0, m_flg[e], 1'b1} : 32'd0;
        e_w1    = e_hit ? {m_base[e], 5'd0} : 32'd0;
        @(posedge clk);
        #1;
        chk(req, "valid", {31'd0, lk_valid}, {31'd0, e_valid});
        chk(req, "hit",   {31'd0, lk_hit},   {31'd0, e_hit});
        chk(req, "word0", lk_word0, e_w0);
        chk(req, "word1", lk_word1, e_w1);
        if (inv_all_en) begin
            for (int i = 0; i < 32; i++) m_good[i] = 0;
        end else if (inv_sect_en) begin
            for (int i = 0; i < 8; i++) m_good[inv_sect_id*8 + i] = 0;
        end else if (inv_ent_en) begin
            m_good[ent_of(inv_ent_va)] = 0;
        end else if (fill_en) begin
            if (fill_rec && fill_w0[6] && fill_w0[0]) begin
                e = ent_of(fill_va);
                m_good[e] = 1; m_tag[e] = fill_va[29:20];
                m_acc[e] = fill_w0[31:10]; m_flg[e] = fill_w0[4:1];
                m_base[e] = fill_w1[31:5];
            end
        end else if (mod_en) begin
            m_flg[ent_of(mod_va)][0] = 1;
        end
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_fill(input logic [31:0] va, input logic [31:0] w0,
                           input logic [31:0] w1, input logic rec, input string req);
        fill_en = 1; fill_rec = rec; fill_va = va; fill_w0 = w0; fill_w1 = w1;
        cycle(req);
    endtask

    task automatic do_look(input logic [31:0] va, input string req);
        lk_req = 1; lk_va = va;
        cycle(req);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] va_a, va_b;
        void'($urandom(32'h5DC0_1A77));
        for (int i = 0; i < 32; i++) begin
            m_good[i] = 0; m_tag[i] = 0; m_acc[i] = 0; m_base[i] = 0; m_flg[i] = 0;
        end
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: after reset all entries miss
        for (int s = 0; s < 4; s++) do_look(mk_va(s, s * 2, 5), "R1");

        // R3/R4/R5: fill and read back
        va_a = mk_va(2, 5, 10'h155);
        do_fill(va_a, 32'hA5C3_F45B, 32'h1234_567F, 1, "R3");
        do_look(va_a, "R4");
        // R2: same index other tag misses
        va_b = mk_va(2, 5, 10'h0AA);
        do_look(va_b, "R2");
        // R3: not valid / not present / not recording -> no store
        do_fill(va_b, 32'hFFFF_FFBF, 32'hFFFF_FFFF, 1, "R3");
        do_fill(va_b, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 1, "R3");
        do_fill(va_b, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R3");
        do_look(va_a, "R3");
        // R9: modified update
        mod_en = 1; mod_va = va_b; cycle("R9");
        do_look(va_a, "R9");
        // R6: entry flush via different tag at same index
        inv_ent_en = 1; inv_ent_va = va_b; cycle("R6");
        do_look(va_a, "R6");
        // R11: fill together with entry flush at same index -> flush wins
        do_fill(va_a, 32'h0000_0441, 32'h8000_0000, 1, "R11");
        fill_en = 1; fill_rec = 1; fill_va = va_b; fill_w0 = 32'hFFFF_FFFF; fill_w1 = 32'h1;
        inv_ent_en = 1; inv_ent_va = va_a; lk_req = 1; lk_va = va_a;
        cycle("R11");
        do_look(va_a, "R11");
        // R7: section flush leaves other sections
        do_fill(mk_va(1, 0, 3), 32'h0000_0041, 32'h0000_0020, 1, "R7");
        do_fill(mk_va(2, 7, 3), 32'h0000_0041, 32'h0000_0040, 1, "R7");
        inv_sect_en = 1; inv_sect_id = 2'd1; cycle("R7");
        do_look(mk_va(1, 0, 3), "R7");
        do_look(mk_va(2, 7, 3), "R7");
        // R8 and R10 idle
        inv_all_en = 1; cycle("R8");
        do_look(mk_va(2, 7, 3), "R8");
        cycle("R10");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int p;
            p = $urandom_range(0, 99);
            lk_req = ($urandom_range(0, 9) < 6);
            lk_va  = mk_va($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 2));
            fill_en = (p < 35);
            fill_rec = ($urandom_range(0, 9) != 0);
            fill_va = mk_va($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 2));
            fill_w0 = $urandom | (($urandom_range(0, 9) != 0) ? 32'h41 : 32'h0);
            fill_w1 = $urandom;
            inv_ent_en = (p >= 35 && p < 42) || ($urandom_range(0, 19) == 0);
            inv_ent_va = mk_va($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 2));
            inv_sect_en = ($urandom_range(0, 39) == 0);
            inv_sect_id = 2'($urandom_range(0, 3));
            inv_all_en = ($urandom_range(0, 199) == 0);
            mod_en = (p >= 42 && p < 52) || ($urandom_range(0, 19) == 0);
            mod_va = mk_va($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 2));
            cycle("R2");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule